// File: doc/BRIEF.md
# Disk DMA Transfer Sequencer

This block is the control logic between a descriptor-driven DMA channel and a block storage back end. It runs one disk command at a time. A start pulse loads how many bytes the command still has to move and clears a running byte index. The block then raises `active` and pulses `kick` so the channel begins handing over chunks. Each chunk is a memory address and a byte length. For each chunk the sequencer issues one request to the back end. The request carries the device byte offset, which the sequencer computes from the command's sector or LBA plus the running index. When the remaining count reaches zero or below, the sequencer completes the command.

Two device kinds are supported. Hard disks use 512-byte sectors and accept read, write and trim. Optical (packet) devices always read, using 2048-byte blocks. An optical command whose LBA is all ones is a non-block transfer: the sequencer issues a single copy request and then completes the command. Every way a segment or command can end pulses `dma_end` back to the channel. A chunk that arrives while no command is active is left in place, and the block reports a pause.

Top module: `disk_dma_seq`

## Requirements
- R1: A `start` pulse is followed one cycle later by a one-cycle `kick` with `active` high. The running index is set to 0. The remaining count becomes `sector_count`×512 for a hard disk, or `packet_size` for an optical device.
- R2: While `active` is low, a presented chunk is not accepted (`chunk_ready` low). `paused` pulses one cycle later and no request is issued.
- R3: A hard-disk request carries offset (`cur_sector`<<9) + index. After each issued chunk, the index grows by the chunk length and the remaining count shrinks by the same amount.
- R4: An optical request carries offset (`lba`<<11) + index.
- R5: `req_op` encodes 0 = read, 1 = write, 2 = trim, 3 = direct copy. A hard disk passes `cmd_kind` through to `req_op`. An optical device always issues 0, except in non-block mode, which issues 3.
- R6: A zero-length chunk is accepted and pulses `dma_end`. It issues no request, signals no completion, and leaves `active` high.
- R7: When a hard-disk request is acknowledged and the remaining count is ≤ 0, `disk_irq` and `dma_end` pulse together and `active` falls.
- R8: When an optical block request is acknowledged and the remaining count is ≤ 0, `cmd_ok` and `dma_end` pulse together and `active` falls.
- R9: With `lba` all ones on an optical device, a single request of op 3 is issued with length min(remaining, chunk length). Its acknowledge completes the command with `cmd_ok`.
- R10: An acknowledge with `req_err` high pulses `cmd_err` and `dma_end` and clears `active`. At most one of `disk_irq`, `cmd_ok` and `cmd_err` is high in any cycle.
- R11: A hard-disk command with `cmd_kind` = 3 pulses `cmd_err` and `dma_end` at its first chunk, issues no request, and clears `active`.
- R12: An acknowledge that leaves the remaining count above zero pulses only `dma_end`, and `active` stays high.
- R13: A chunk that arrives while the remaining count is already ≤ 0 completes the command at once, with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (accepted when no request is outstanding) |
| is_optical | input | 1 | 1 = optical packet device, 0 = hard disk |
| cmd_kind | input | 2 | Disk command: 0 read, 1 write, 2 trim |
| sector_count | input | CNT_W | Disk sector count |
| packet_size | input | SIZE_W | Optical transfer size in bytes |
| cur_sector | input | LBA_W | Disk starting sector |
| lba | input | LBA_W | Optical starting block (all ones = non-block) |
| kick | output | 1 | Pulse asking the DMA channel to run |
| active | output | 1 | Command in progress |
| chunk_valid | input | 1 | DMA chunk presented |
| chunk_addr | input | ADDR_W | Chunk memory address |
| chunk_len | input | LEN_W | Chunk length in bytes |
| chunk_ready | output | 1 | Chunk accepted this cycle |
| paused | output | 1 | Pulse: chunk seen while inactive |
| req_valid | output | 1 | Back-end request pending |
| req_op | output | 2 | Request op (R5) |
| req_addr | output | ADDR_W | Memory address of the request |
| req_len | output | LEN_W | Request length in bytes |
| req_offset | output | OFF_W | Device byte offset |
| req_ack | input | 1 | Back end finished the request |
| req_err | input | 1 | Back-end error, valid with `req_ack` |
| dma_end | output | 1 | Pulse: segment or command ended |
| disk_irq | output | 1 | Pulse: hard-disk completion |
| cmd_ok | output | 1 | Pulse: optical completion |
| cmd_err | output | 1 | Pulse: error completion |

## Verification
The assertions hold the cycle-level rules at all times:
- A request stays steady until it is acknowledged.
- Every completion or error coincides with `dma_end`.
- Completion outcomes are mutually exclusive.
- `kick` only appears with `active`.
- A pause never coincides with a request.

The directed scenarios are the only place where the arithmetic and the decisions made at each chunk are checked: the offset scaling for each device kind, the index carried across several chunks, the copy length in non-block mode, and the choice between a bare segment end and a full completion.

// File: rtl/disk_dma_seq.sv
module disk_dma_seq #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 16,
  parameter int LBA_W  = 32,
  parameter int SIZE_W = 32,
  parameter int OFF_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_optical,
  input  logic [1:0]        cmd_kind,
  input  logic [CNT_W-1:0]  sector_count,
  input  logic [SIZE_W-1:0] packet_size,
  input  logic [LBA_W-1:0]  cur_sector,
  input  logic [LBA_W-1:0]  lba,
  output logic              kick,
  output logic              active,
  input  logic              chunk_valid,
  input  logic [ADDR_W-1:0] chunk_addr,
  input  logic [LEN_W-1:0]  chunk_len,
  output logic              chunk_ready,
  output logic              paused,
  output logic              req_valid,
  output logic [1:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [OFF_W-1:0]  req_offset,
  input  logic              req_ack,
  input  logic              req_err,
  output logic              dma_end,
  output logic              disk_irq,
  output logic              cmd_ok,
  output logic              cmd_err
);
  localparam int REM_W = SIZE_W + 1;
  localparam logic [1:0] OP_READ = 2'd0, OP_COPY = 2'd3;

  logic             opt_q, nonblk_q, copy_q;
  logic [1:0]       kind_q;
  logic [LBA_W-1:0] base_q;
  logic [REM_W-1:0] rem_q;
  logic [SIZE_W-1:0] idx_q;

  wire rem_le0   = rem_q[REM_W-1] | (rem_q == '0);
  wire take      = chunk_valid && !req_valid && !start;
  wire [REM_W-1:0] len_ext = REM_W'(chunk_len);
  wire [LEN_W-1:0] copy_len = (rem_q < len_ext) ? rem_q[LEN_W-1:0] : chunk_len;
  wire [OFF_W-1:0] base_ext = OFF_W'(base_q);
  wire [OFF_W-1:0] off_now  = (opt_q ? (base_ext << 11) : (base_ext << 9)) + OFF_W'(idx_q);

  assign chunk_ready = take && active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opt_q <= 1'b0; nonblk_q <= 1'b0; copy_q <= 1'b0; kind_q <= '0;
      base_q <= '0; rem_q <= '0; idx_q <= '0; active <= 1'b0; kick <= 1'b0;
      paused <= 1'b0; req_valid <= 1'b0; req_op <= '0; req_addr <= '0;
      req_len <= '0; req_offset <= '0; dma_end <= 1'b0; disk_irq <= 1'b0;
      cmd_ok <= 1'b0; cmd_err <= 1'b0;
    end else begin
      kick <= 1'b0; paused <= 1'b0; dma_end <= 1'b0;
      disk_irq <= 1'b0; cmd_ok <= 1'b0; cmd_err <= 1'b0;
      if (start && !req_valid) begin
        opt_q    <= is_optical;
        kind_q   <= cmd_kind;
        base_q   <= is_optical ? lba : cur_sector;
        nonblk_q <= is_optical && (&lba);
        rem_q    <= is_optical ? REM_W'(packet_size) : REM_W'({sector_count, 9'd0});
        idx_q    <= '0;
        active   <= 1'b1;
        kick     <= 1'b1;
      end else if (take && !active) begin
        paused <= 1'b1;
      end else if (take) begin
        if (rem_le0) begin
          dma_end  <= 1'b1;
          active   <= 1'b0;
          disk_irq <= !opt_q;
          cmd_ok   <= opt_q;
        end else if (chunk_len == '0) begin
          dma_end <= 1'b1;
        end else if (nonblk_q) begin
          req_valid  <= 1'b1;
          copy_q     <= 1'b1;
          req_op     <= OP_COPY;
          req_addr   <= chunk_addr;
          req_len    <= copy_len;
          req_offset <= '0;
        end else if (!opt_q && kind_q == 2'd3) begin
          cmd_err <= 1'b1;
          dma_end <= 1'b1;
          active  <= 1'b0;
        end else begin
          req_valid  <= 1'b1;
          copy_q     <= 1'b0;
          req_op     <= opt_q ? OP_READ : kind_q;
          req_addr   <= chunk_addr;
          req_len    <= chunk_len;
          req_offset <= off_now;
          rem_q      <= rem_q - len_ext;
          idx_q      <= idx_q + SIZE_W'(chunk_len);
        end
      end else if (req_valid && req_ack) begin
        req_valid <= 1'b0;
        dma_end   <= 1'b1;
        if (req_err) begin
          cmd_err <= 1'b1;
          active  <= 1'b0;
        end else if (copy_q) begin
          cmd_ok <= 1'b1;
          active <= 1'b0;
        end else if (rem_le0) begin
          disk_irq <= !opt_q;
          cmd_ok   <= opt_q;
          active   <= 1'b0;
        end
      end
    end
  end

  a_r1_kick_with_active: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> active);
  a_r2_pause_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !req_valid);
  a_r3_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ack |=> req_valid && $stable(req_offset) && $stable(req_len) && $stable(req_op));
  a_r7_irq_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
    disk_irq |-> !active && dma_end);
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({disk_irq, cmd_ok, cmd_err}));
  a_r12_outcome_ends_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok || cmd_err) |-> dma_end && !active);
endmodule

// File: tb/tb_disk_dma_seq.sv
module tb_disk_dma_seq;
  logic clk = 0, rst_n = 0;
  logic start = 0, is_optical = 0;
  logic [1:0] cmd_kind = 0;
  logic [15:0] sector_count = 0;
  logic [31:0] packet_size = 0, cur_sector = 0, lba = 0;
  logic chunk_valid = 0, req_ack = 0, req_err = 0;
  logic [31:0] chunk_addr = 0;
  logic [15:0] chunk_len = 0;
  logic kick, active, chunk_ready, paused, req_valid, dma_end, disk_irq, cmd_ok, cmd_err;
  logic [1:0] req_op;
  logic [31:0] req_addr;
  logic [15:0] req_len;
  logic [47:0] req_offset;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  disk_dma_seq dut (.*);

  task automatic chk(string rq, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask

  task automatic begin_cmd(bit opt, logic [1:0] k, logic [15:0] ns, logic [31:0] ps, logic [31:0] sec, logic [31:0] lb);
    is_optical = opt; cmd_kind = k; sector_count = ns; packet_size = ps; cur_sector = sec; lba = lb;
    start = 1; cyc(); start = 0;
  endtask

  task automatic chunk(logic [31:0] a, logic [15:0] l);
    chunk_addr = a; chunk_len = l; chunk_valid = 1; cyc(); chunk_valid = 0;
  endtask

  task automatic ack(bit e);
    req_ack = 1; req_err = e; cyc(); req_ack = 0; req_err = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset active", active, 0);
    chk("R1 reset req_valid", req_valid, 0);
  endtask

  task automatic t_disk_write();
    begin_cmd(0, 1, 2, 0, 100, 0);
    chk("R1 kick", kick, 1);
    chk("R1 active", active, 1);
    chunk(32'h1000, 512);
    chk("R3 req_valid", req_valid, 1);
    chk("R3 offset first", req_offset, 51200);
    chk("R5 op write", req_op, 1);
    chk("R3 len", req_len, 512);
    ack(0);
    chk("R12 dma_end", dma_end, 1);
    chk("R12 no irq", disk_irq, 0);
    chk("R12 still active", active, 1);
    chunk(32'h2000, 512);
    chk("R3 offset second", req_offset, 51712);
    ack(0);
    chk("R7 irq", disk_irq, 1);
    chk("R7 dma_end", dma_end, 1);
    chk("R7 inactive", active, 0);
    chunk_addr = 0; chunk_len = 64; chunk_valid = 1; #0;
    chk("R2 not ready", chunk_ready, 0);
    cyc(); chunk_valid = 0;
    chk("R2 paused", paused, 1);
    chk("R2 no request", req_valid, 0);
  endtask

  task automatic t_optical();
    begin_cmd(1, 1, 0, 4096, 0, 5);
    chunk(32'h3000, 2048);
    chk("R4 offset first", req_offset, 10240);
    chk("R5 optical read", req_op, 0);
    ack(0);
    chk("R12 optical segment", cmd_ok, 0);
    chunk(32'h4000, 2048);
    chk("R4 offset second", req_offset, 12288);
    ack(0);
    chk("R8 cmd_ok", cmd_ok, 1);
    chk("R8 dma_end", dma_end, 1);
    chk("R8 inactive", active, 0);
  endtask

  task automatic t_nonblock();
    begin_cmd(1, 0, 0, 100, 0, 32'hFFFF_FFFF);
    chunk(32'h5000, 512);
    chk("R9 op copy", req_op, 3);
    chk("R9 len min", req_len, 100);
    chk("R9 addr", req_addr, 32'h5000);
    ack(0);
    chk("R9 cmd_ok", cmd_ok, 1);
    chk("R9 inactive", active, 0);
  endtask

  task automatic t_zero_len();
    begin_cmd(0, 2, 1, 0, 7, 0);
    chunk(32'h6000, 0);
    chk("R6 dma_end", dma_end, 1);
    chk("R6 no request", req_valid, 0);
    chk("R6 no irq", disk_irq, 0);
    chk("R6 active", active, 1);
    chunk(32'h6000, 512);
    chk("R5 op trim", req_op, 2);
    chk("R3 offset trim", req_offset, 3584);
    ack(1);
    chk("R10 cmd_err", cmd_err, 1);
    chk("R10 dma_end", dma_end, 1);
    chk("R10 inactive", active, 0);
  endtask

  task automatic t_bad_cmd();
    begin_cmd(0, 3, 1, 0, 0, 0);
    chunk(32'h7000, 512);
    chk("R11 cmd_err", cmd_err, 1);
    chk("R11 no request", req_valid, 0);
    chk("R11 dma_end", dma_end, 1);
    chk("R11 inactive", active, 0);
  endtask

  task automatic t_empty();
    begin_cmd(1, 0, 0, 0, 0, 9);
    chunk(32'h8000, 512);
    chk("R13 cmd_ok", cmd_ok, 1);
    chk("R13 no request", req_valid, 0);
    chk("R13 inactive", active, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        t_reset(); t_disk_write(); t_optical(); t_nonblock();
        t_zero_len(); t_bad_cmd(); t_empty();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule